// File: doc/BRIEF.md
# Register Rename Stage with In-Order Active List

This block renames one instruction per clock. Each logical source register number (5 bits, 32 registers) is translated through a map table into a physical register tag (6 bits, 64 registers). The logical destination receives a fresh physical register taken from a free list, so a later writer never overwrites a value an earlier reader still needs. This removes write-after-read and write-after-write hazards.

Every renamed instruction is appended to an in-order active list. Each entry records the logical destination, the physical register that destination mapped to before the rename, and a completion flag. The entry's slot number is the instruction's 5-bit ID. A busy-bit table tracks, for each physical register, whether its value is still being produced.

A write-back port clears a register's busy bit and marks the matching active-list entry complete. A graduate request retires the oldest entry once it is complete. It reports that entry's logical destination and superseded physical register, and the superseded register goes back onto the free list.

Top module: `reg_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i, no physical register is busy, `rn_ready_o` is 1, `out_valid_o` is 0 and `grad_ack_o` is 0 even with `grad_req_i` high.
- R2: An accepted rename returns the current mappings of both sources. A source equal to the same instruction's destination gets the mapping from before this rename.
- R3: The destination tag comes from the free list in first-in first-out order. After reset the free list holds physical registers 32 to 63 in ascending order. `out_old_tag_o` gives the destination's mapping before the rename.
- R4: A newly assigned destination becomes busy. A later source that maps to it reports busy 1 until its write-back.
- R5: A write-back clears the tag's busy bit. A source read in the same cycle as the write-back of its tag already reports not busy.
- R6: `out_id_o` is the active-list slot, counting up from 0 after reset and wrapping modulo 32.
- R7: With 32 instructions in flight, `rn_ready_o` is 0 and a request with `rn_valid_i` high is not accepted: `out_valid_o` stays 0 in the next cycle.
- R8: `grad_ack_o` is high only when `grad_req_i` is high and the oldest entry is complete. Completed younger entries never graduate ahead of it.
- R9: A graduating entry's old physical register joins the tail of the free list and is handed out again after the registers already on it.
- R10: While `grad_ack_o` is high, `grad_ldst_o` and `grad_old_tag_o` show the oldest entry's logical destination and superseded physical register.
- R11: Rename results (`out_*`) are registered. They appear in the cycle after the accepting clock edge, with `out_valid_o` high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rn_valid_i | input | 1 | Rename request |
| rn_src_a_i | input | 5 | Logical source A |
| rn_src_b_i | input | 5 | Logical source B |
| rn_dst_i | input | 5 | Logical destination |
| rn_ready_o | output | 1 | Rename can be accepted this cycle |
| out_valid_o | output | 1 | Registered rename result valid |
| out_src_a_tag_o | output | 6 | Physical tag of source A |
| out_src_b_tag_o | output | 6 | Physical tag of source B |
| out_src_a_busy_o | output | 1 | Source A value not yet produced |
| out_src_b_busy_o | output | 1 | Source B value not yet produced |
| out_dst_tag_o | output | 6 | Newly assigned physical destination |
| out_old_tag_o | output | 6 | Previous physical mapping of the destination |
| out_id_o | output | 5 | Active-list slot (instruction ID) |
| wb_valid_i | input | 1 | Write-back strobe |
| wb_tag_i | input | 6 | Physical register written back |
| wb_id_i | input | 5 | Instruction ID completing |
| grad_req_i | input | 1 | Request to retire the oldest instruction |
| grad_ack_o | output | 1 | Oldest instruction retires this cycle |
| grad_ldst_o | output | 5 | Logical destination of the retiring instruction |
| grad_old_tag_o | output | 6 | Physical register being released |

## Verification
A directed rename whose sources equal its own destination separates read-before-update ordering from a design that forwards the new tag. A source read in the same cycle as its write-back exposes a missing busy bypass. A long run of renames with no write-backs fills the active list and shows whether the stall engages at exactly 32. Write-backs delivered out of order, combined with graduate requests, separate strict in-order retirement from retiring any completed entry. A long constrained-random mix of renames, write-backs and graduations recycles every physical register many times, so a wrong free-list order or a lost tag shows up as a mismatched destination tag.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned DEF_NUM_LOG  = 32;
  localparam int unsigned DEF_NUM_PHYS = 64;
  localparam int unsigned DEF_AL_DEPTH = 32;

  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NUM_LOG  = 32,
  parameter int unsigned NUM_PHYS = 64,
  localparam int unsigned LW = $clog2(NUM_LOG),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rd_a_idx,
  input  logic [LW-1:0] rd_b_idx,
  input  logic [LW-1:0] rd_d_idx,
  output logic [PW-1:0] rd_a_tag,
  output logic [PW-1:0] rd_b_tag,
  output logic [PW-1:0] rd_d_tag,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [PW-1:0] wr_tag
);
  logic [PW-1:0] map_q [NUM_LOG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LOG; i++) map_q[i] <= PW'(i);
    end else if (wr_en) begin
      map_q[wr_idx] <= wr_tag;
    end
  end

  assign rd_a_tag = map_q[rd_a_idx];
  assign rd_b_tag = map_q[rd_b_idx];
  assign rd_d_tag = map_q[rd_d_idx];

  assert_map_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> map_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned NUM_PHYS   = 64,
  parameter int unsigned FIRST_FREE = 32,
  localparam int unsigned DEPTH = NUM_PHYS - FIRST_FREE,
  localparam int unsigned PW    = $clog2(NUM_PHYS),
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  output logic [PW-1:0] pop_tag,
  output logic          empty,
  input  logic          push,
  input  logic [PW-1:0] push_tag,
  output logic [CW-1:0] count
);
  logic [PW-1:0] mem_q [DEPTH];
  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= PW'(FIRST_FREE + i);
    end else if (push) begin
      mem_q[tail_q] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CW'(DEPTH);
    end else begin
      if (pop)  head_q <= AW'(rn_pkg::ptr_next(int'(head_q), DEPTH));
      if (push) tail_q <= AW'(rn_pkg::ptr_next(int'(tail_q), DEPTH));
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign pop_tag = mem_q[head_q];
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt_q != '0);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q != CW'(DEPTH)) || pop);
endmodule

// File: rtl/rn_active_list.sv
module rn_active_list #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LW    = 5,
  parameter int unsigned PW    = 6,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_ldst,
  input  logic [PW-1:0] push_old,
  output logic [IW-1:0] tail_id,
  output logic          full,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_id,
  input  logic          grad_req,
  output logic          grad_ack,
  output logic [LW-1:0] head_ldst,
  output logic [PW-1:0] head_old,
  output logic [CW-1:0] count
);
  logic [LW-1:0]    ldst_mem [DEPTH];
  logic [PW-1:0]    old_mem  [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic [IW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (push) begin
      ldst_mem[tail_q] <= push_ldst;
      old_mem[tail_q]  <= push_old;
    end
  end

  assign grad_ack = grad_req && (cnt_q != '0) && done_q[head_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wb_en)    done_q[wb_id]  <= 1'b1;
      if (push)     done_q[tail_q] <= 1'b0;
      if (push)     tail_q <= IW'(rn_pkg::ptr_next(int'(tail_q), DEPTH));
      if (grad_ack) head_q <= IW'(rn_pkg::ptr_next(int'(head_q), DEPTH));
      case ({push, grad_ack})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign tail_id   = tail_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign head_ldst = ldst_mem[head_q];
  assign head_old  = old_mem[head_q];
  assign count     = cnt_q;

  assert_push_not_full_R7: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_id_advances_R6: assert property (@(posedge clk) disable iff (rst)
    push |=> tail_q == IW'(rn_pkg::ptr_next(int'($past(tail_q)), DEPTH)));
  assert_new_entry_pending_R8: assert property (@(posedge clk) disable iff (rst)
    push |=> !done_q[$past(tail_q)]);
endmodule

// File: rtl/rn_busy_table.sv
module rn_busy_table #(
  parameter int unsigned NUM_PHYS = 64,
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] rd_a_tag,
  input  logic [PW-1:0] rd_b_tag,
  output logic          rd_a_busy,
  output logic          rd_b_busy,
  input  logic          set_en,
  input  logic [PW-1:0] set_tag,
  input  logic          clr_en,
  input  logic [PW-1:0] clr_tag
);
  logic [NUM_PHYS-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
    end else begin
      if (clr_en) busy_q[clr_tag] <= 1'b0;
      if (set_en) busy_q[set_tag] <= 1'b1;
    end
  end

  assign rd_a_busy = busy_q[rd_a_tag] && !(clr_en && clr_tag == rd_a_tag);
  assign rd_b_busy = busy_q[rd_b_tag] && !(clr_en && clr_tag == rd_b_tag);

  assert_new_dst_busy_R4: assert property (@(posedge clk) disable iff (rst)
    set_en |=> busy_q[$past(set_tag)]);
  assert_wb_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_tag == clr_tag)) |=> !busy_q[$past(clr_tag)]);
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int unsigned NUM_LOG  = rn_pkg::DEF_NUM_LOG,
  parameter int unsigned NUM_PHYS = rn_pkg::DEF_NUM_PHYS,
  parameter int unsigned AL_DEPTH = rn_pkg::DEF_AL_DEPTH,
  localparam int unsigned LW  = $clog2(NUM_LOG),
  localparam int unsigned PW  = $clog2(NUM_PHYS),
  localparam int unsigned IW  = $clog2(AL_DEPTH),
  localparam int unsigned FCW = $clog2(NUM_PHYS - NUM_LOG + 1),
  localparam int unsigned ACW = $clog2(AL_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rn_valid_i,
  input  logic [LW-1:0] rn_src_a_i,
  input  logic [LW-1:0] rn_src_b_i,
  input  logic [LW-1:0] rn_dst_i,
  output logic          rn_ready_o,
  output logic          out_valid_o,
  output logic [PW-1:0] out_src_a_tag_o,
  output logic [PW-1:0] out_src_b_tag_o,
  output logic          out_src_a_busy_o,
  output logic          out_src_b_busy_o,
  output logic [PW-1:0] out_dst_tag_o,
  output logic [PW-1:0] out_old_tag_o,
  output logic [IW-1:0] out_id_o,
  input  logic          wb_valid_i,
  input  logic [PW-1:0] wb_tag_i,
  input  logic [IW-1:0] wb_id_i,
  input  logic          grad_req_i,
  output logic          grad_ack_o,
  output logic [LW-1:0] grad_ldst_o,
  output logic [PW-1:0] grad_old_tag_o
);
  logic           fire;
  logic [PW-1:0]  map_a, map_b, map_d;
  logic [PW-1:0]  fl_tag;
  logic           fl_empty;
  logic [FCW-1:0] fl_count;
  logic           al_full;
  logic [IW-1:0]  al_tail;
  logic [ACW-1:0] al_count;
  logic           busy_a, busy_b;

  assign rn_ready_o = !fl_empty && !al_full;
  assign fire       = rn_valid_i && rn_ready_o;

  rn_map_table #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk(clk), .rst(rst),
    .rd_a_idx(rn_src_a_i), .rd_b_idx(rn_src_b_i), .rd_d_idx(rn_dst_i),
    .rd_a_tag(map_a), .rd_b_tag(map_b), .rd_d_tag(map_d),
    .wr_en(fire), .wr_idx(rn_dst_i), .wr_tag(fl_tag)
  );

  rn_free_list #(.NUM_PHYS(NUM_PHYS), .FIRST_FREE(NUM_LOG)) u_free (
    .clk(clk), .rst(rst),
    .pop(fire), .pop_tag(fl_tag), .empty(fl_empty),
    .push(grad_ack_o), .push_tag(grad_old_tag_o), .count(fl_count)
  );

  rn_active_list #(.DEPTH(AL_DEPTH), .LW(LW), .PW(PW)) u_al (
    .clk(clk), .rst(rst),
    .push(fire), .push_ldst(rn_dst_i), .push_old(map_d),
    .tail_id(al_tail), .full(al_full),
    .wb_en(wb_valid_i), .wb_id(wb_id_i),
    .grad_req(grad_req_i), .grad_ack(grad_ack_o),
    .head_ldst(grad_ldst_o), .head_old(grad_old_tag_o), .count(al_count)
  );

  rn_busy_table #(.NUM_PHYS(NUM_PHYS)) u_busy (
    .clk(clk), .rst(rst),
    .rd_a_tag(map_a), .rd_b_tag(map_b),
    .rd_a_busy(busy_a), .rd_b_busy(busy_b),
    .set_en(fire), .set_tag(fl_tag),
    .clr_en(wb_valid_i), .clr_tag(wb_tag_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o      <= 1'b0;
      out_src_a_tag_o  <= '0;
      out_src_b_tag_o  <= '0;
      out_src_a_busy_o <= 1'b0;
      out_src_b_busy_o <= 1'b0;
      out_dst_tag_o    <= '0;
      out_old_tag_o    <= '0;
      out_id_o         <= '0;
    end else begin
      out_valid_o <= fire;
      if (fire) begin
        out_src_a_tag_o  <= map_a;
        out_src_b_tag_o  <= map_b;
        out_src_a_busy_o <= busy_a;
        out_src_b_busy_o <= busy_b;
        out_dst_tag_o    <= fl_tag;
        out_old_tag_o    <= map_d;
        out_id_o         <= al_tail;
      end
    end
  end

  assert_tag_conservation_R9: assert property (@(posedge clk) disable iff (rst)
    int'(fl_count) + int'(al_count) == int'(NUM_PHYS - NUM_LOG));
  assert_out_follows_accept_R11: assert property (@(posedge clk) disable iff (rst)
    !rn_ready_o |=> !out_valid_o);
  assert_new_not_old_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> out_dst_tag_o != out_old_tag_o);
endmodule

// File: tb/tb_reg_rename.sv
module tb_reg_rename;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rn_valid_i = 1'b0;
  logic [4:0] rn_src_a_i = '0, rn_src_b_i = '0, rn_dst_i = '0;
  logic       rn_ready_o, out_valid_o, out_src_a_busy_o, out_src_b_busy_o;
  logic [5:0] out_src_a_tag_o, out_src_b_tag_o, out_dst_tag_o, out_old_tag_o;
  logic [4:0] out_id_o;
  logic       wb_valid_i = 1'b0;
  logic [5:0] wb_tag_i = '0;
  logic [4:0] wb_id_i = '0;
  logic       grad_req_i = 1'b0;
  logic       grad_ack_o;
  logic [4:0] grad_ldst_o;
  logic [5:0] grad_old_tag_o;

  reg_rename dut (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int m_map [32];
  bit m_busy [64];
  int m_fl [32];
  int fl_head, fl_tail, fl_cnt;
  int al_ldst [32], al_old [32], al_new [32];
  bit al_done [32];
  int al_head, al_tail, al_cnt;
  bit e_v;
  int e_sa, e_sb, e_dst, e_old, e_id;
  bit e_ba, e_bb;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // wmode: 0 none, 1 random pending entry, 2 the entry given by wid
  task automatic cycle(input bit v, input int sa, input int sb, input int d,
                       input bit g, input int wmode, input int wid);
    bit w, fire, ack;
    int wsel, wtag, nt;
    @(negedge clk);
    // R11: registered results from the previous edge
    check("R11 out_valid", out_valid_o, e_v);
    if (e_v) begin
      check("R2 src_a tag", out_src_a_tag_o, e_sa);
      check("R2 src_b tag", out_src_b_tag_o, e_sb);
      check("R4/R5 src_a busy", out_src_a_busy_o, e_ba);
      check("R4/R5 src_b busy", out_src_b_busy_o, e_bb);
      check("R3 dst tag", out_dst_tag_o, e_dst);
      check("R3 old tag", out_old_tag_o, e_old);
      check("R6 id", out_id_o, e_id);
    end
    w = 0; wsel = 0;
    if (wmode == 2) begin
      w = 1; wsel = wid;
    end else if (wmode == 1 && al_cnt > 0) begin
      int start = $urandom_range(al_cnt - 1);
      for (int k = 0; k < al_cnt; k++) begin
        int idx = (al_head + (start + k) % al_cnt) % 32;
        if (!w && !al_done[idx]) begin w = 1; wsel = idx; end
      end
    end
    wtag = w ? al_new[wsel] : 0;
    rn_valid_i = v; rn_src_a_i = 5'(sa); rn_src_b_i = 5'(sb); rn_dst_i = 5'(d);
    grad_req_i = g; wb_valid_i = w; wb_id_i = 5'(wsel); wb_tag_i = 6'(wtag);
    #1;
    check("R7 ready", rn_ready_o, al_cnt < 32);
    ack = g && al_cnt > 0 && al_done[al_head];
    check("R8 grad_ack", grad_ack_o, ack);
    if (ack) begin
      check("R10 grad ldst", grad_ldst_o, al_ldst[al_head]);
      check("R10 grad old", grad_old_tag_o, al_old[al_head]);
    end
    fire = v && al_cnt < 32;
    e_v = fire;
    if (fire) begin
      e_sa = m_map[sa]; e_sb = m_map[sb];
      e_ba = m_busy[e_sa] && !(w && wtag == e_sa);
      e_bb = m_busy[e_sb] && !(w && wtag == e_sb);
      e_dst = m_fl[fl_head]; e_old = m_map[d]; e_id = al_tail;
    end
    if (w) begin m_busy[wtag] = 0; al_done[wsel] = 1; end
    if (fire) begin
      nt = m_fl[fl_head]; fl_head = (fl_head + 1) % 32; fl_cnt--;
      al_ldst[al_tail] = d; al_old[al_tail] = m_map[d]; al_new[al_tail] = nt;
      al_done[al_tail] = 0; al_tail = (al_tail + 1) % 32; al_cnt++;
      m_map[d] = nt; m_busy[nt] = 1;
    end
    if (ack) begin
      m_fl[fl_tail] = al_old[al_head]; fl_tail = (fl_tail + 1) % 32; fl_cnt++;
      al_head = (al_head + 1) % 32; al_cnt--;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) begin m_map[i] = i; m_fl[i] = 32 + i; al_done[i] = 0; end
    for (int i = 0; i < 64; i++) m_busy[i] = 0;
    fl_head = 0; fl_tail = 0; fl_cnt = 32; al_head = 0; al_tail = 0; al_cnt = 0; e_v = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    grad_req_i = 1'b1;
    #1;
    // R1 reset state
    check("R1 ready after reset", rn_ready_o, 1);
    check("R1 out_valid after reset", out_valid_o, 0);
    check("R1 no graduation when empty", grad_ack_o, 0);
    grad_req_i = 1'b0;
    // R1/R2/R3: identity map, source equal to destination reads the old mapping
    cycle(1, 5, 5, 5, 0, 0, 0);
    // R4: source reads a freshly renamed destination
    cycle(1, 5, 7, 9, 0, 0, 0);
    // R5: write-back of id 0 (tag 32) in the same cycle as a read of it
    cycle(1, 5, 9, 3, 0, 2, 0);
    cycle(1, 9, 5, 4, 0, 0, 0);
    // R7: fill the active list without write-backs and hold the stall
    for (int i = 0; i < 34; i++) cycle(1, $urandom_range(31), $urandom_range(31), $urandom_range(31), 0, 0, 0);
    // R8: id 0 is complete and graduates; then id 2 completes out of order
    cycle(1, 1, 2, 3, 1, 2, 2);
    cycle(0, 0, 0, 0, 1, 0, 0);
    cycle(0, 0, 0, 0, 1, 2, 1);
    cycle(0, 0, 0, 0, 1, 0, 0);
    cycle(0, 0, 0, 0, 1, 0, 0);
    // R9: renames after graduation reuse the released registers
    for (int i = 0; i < 4; i++) cycle(1, $urandom_range(31), $urandom_range(31), $urandom_range(31), 0, 0, 0);
    // Mixed random traffic
    for (int i = 0; i < 4000; i++)
      cycle($urandom_range(99) < 70, $urandom_range(31), $urandom_range(31), $urandom_range(31),
            $urandom_range(99) < 60, ($urandom_range(99) < 65) ? 1 : 0, 0);
    for (int i = 0; i < 80; i++) cycle(0, 0, 0, 0, 1, 1, 0);
    cycle(0, 0, 0, 0, 0, 0, 0);
    check("R9 all entries retired", al_cnt, 0);
    finish_run();
  end
endmodule